// File: doc/BRIEF.md
# Vector Access Line Coalescer

This block accepts one vector memory instruction at a time from a group of parallel threads. Each thread supplies a byte address and an active bit. The whole instruction shares a single read/write flag. The block turns the per-thread accesses into a series of line-sized memory transactions, at most one per cycle.

In every cycle it takes the lowest-numbered thread that is still waiting as the leader. It then gathers every other waiting thread whose address lies in the same aligned line as the leader's. The result goes out as one transaction that carries the line address and a mask of the threads it serves. Those threads are then retired, and this repeats until no thread is waiting. Threads spread across distinct lines therefore cost one transaction each. Threads that share a line cost one transaction in total.

The instruction input and the transaction output are both valid/ready streams.
- The block raises `in_ready` only when it is idle, so an offer made while busy is ignored.
- On the output, a transaction is presented with `tx_valid` and stays unchanged until `tx_ready` is sampled high at a clock edge.
- Once the last transaction of an instruction has been accepted, `busy` falls and `done` pulses for one cycle.

Top module: `simt_coalescer`

## Requirements
- R1: While reset is held and after reset ends, `tx_valid`, `busy` and `done` are 0 and `in_ready` is 1.
- R2: An instruction is taken only at a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 whenever `busy` is 1. An offer made while busy has no effect on the transactions of the instruction in flight.
- R3: The leader of each transaction is the lowest-numbered thread that is active and not yet served. Transactions therefore appear in ascending order of their lowest thread index.
- R4: A transaction's mask contains every unserved active thread whose address bits above the line offset equal the leader's. The offset is log2(LINE_BYTES) bits wide: 6 bits at the default of 64, and LINE_BYTES may be 32, 64 or 128.
- R5: `tx_line_addr` is the leader's address with the low log2(LINE_BYTES) bits cleared.
- R6: Each active thread appears in exactly one transaction mask per instruction, and consecutive masks never overlap.
- R7: An inactive thread never appears in any transaction mask.
- R8: An instruction with no active thread produces no transaction, leaves `busy` at 0, and pulses `done` in the cycle after its acceptance.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_line_addr`, `tx_mask` and `tx_write` hold their values into the next cycle.
- R10: In the cycle after the last transaction handshake, `done` is 1 for exactly that cycle and `busy` is 0. A new instruction may be accepted in that same cycle.
- R11: `tx_write` equals the `in_write` value captured with the instruction.
- R12: The number of transactions equals the number of distinct lines among the active threads. For example, threads strided a line or more apart give one transaction per thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block is idle and will take an instruction |
| in_write | input | 1 | 1 for a store, 0 for a load |
| in_active | input | N_THREADS | Per-thread active bits |
| in_addr | input | N_THREADS*ADDR_W | Per-thread byte addresses; thread i at bits [i*ADDR_W +: ADDR_W] |
| tx_valid | output | 1 | Transaction presented |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_write | output | 1 | Store flag of the transaction |
| tx_line_addr | output | ADDR_W | Aligned line address |
| tx_mask | output | N_THREADS | Threads served by the transaction |
| busy | output | 1 | An instruction is being drained |
| done | output | 1 | One-cycle pulse when an instruction has finished |

## Verification
Two events can share a single cycle: the completion pulse of one instruction and the acceptance of the next. The bench issues instructions back to back. It offers each new instruction in the very cycle where it expects `done` from the previous one. It then checks that `done` is 1, `in_ready` is 1, and that the next instruction's first transaction appears one cycle later with the correct leader and mask. Random stalls on `tx_ready` put retirement of the final line and output back-pressure in the same cycle, and the bench then checks that nothing presented changes while the stall lasts.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Line sizes the merge comparator is specified for.
  function automatic bit line_size_legal(input int bytes);
    return (bytes == 32) || (bytes == 64) || (bytes == 128);
  endfunction

  function automatic int offset_bits(input int bytes);
    return $clog2(bytes);
  endfunction
endpackage

// File: rtl/coal_leader_pick.sv
// Lowest-index selector over the set of waiting threads.
module coal_leader_pick #(
  parameter int N_THREADS = 32,
  localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic [N_THREADS-1:0] waiting,
  output logic [TID_W-1:0]     lead_idx,
  output logic                 any_waiting
);
  always_comb begin
    lead_idx    = '0;
    any_waiting = 1'b0;
    for (int i = N_THREADS - 1; i >= 0; i--) begin
      if (waiting[i]) begin
        lead_idx    = TID_W'(i);
        any_waiting = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_line_match.sv
// Per-thread comparison of line tags against the leader's tag.
module coal_line_match #(
  parameter int N_THREADS = 32,
  parameter int ADDR_W    = 32,
  parameter int OFFS_W    = 6,
  localparam int TAG_W    = ADDR_W - OFFS_W
) (
  input  logic [N_THREADS*ADDR_W-1:0] addrs,
  input  logic [N_THREADS-1:0]        waiting,
  input  logic [TAG_W-1:0]            lead_tag,
  output logic [N_THREADS-1:0]        hit
);
  for (genvar g = 0; g < N_THREADS; g++) begin : g_cmp
    logic [TAG_W-1:0] tag_g;
    assign tag_g  = addrs[g*ADDR_W+OFFS_W +: TAG_W];
    assign hit[g] = waiting[g] && (tag_g == lead_tag);
  end
endmodule

// File: rtl/coal_instr_reg.sv
// Holds the instruction in flight and its set of unserved threads.
module coal_instr_reg #(
  parameter int N_THREADS = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        ld_write,
  input  logic [N_THREADS-1:0]        ld_active,
  input  logic [N_THREADS*ADDR_W-1:0] ld_addr,
  input  logic                        retire,
  input  logic [N_THREADS-1:0]        retire_mask,
  output logic [N_THREADS-1:0]        waiting_q,
  output logic                        write_q,
  output logic [N_THREADS*ADDR_W-1:0] addr_q,
  output logic                        fin_q
);
  logic [N_THREADS-1:0] remain;
  assign remain = waiting_q & ~retire_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting_q <= '0;
      write_q   <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        waiting_q <= ld_active;
        write_q   <= ld_write;
        fin_q     <= (ld_active == '0);
      end else if (retire) begin
        waiting_q <= remain;
        fin_q     <= (remain == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) addr_q <= ld_addr;
  end
endmodule

// File: rtl/simt_coalescer.sv
module simt_coalescer #(
  parameter int N_THREADS  = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_write,
  input  logic [N_THREADS-1:0]        in_active,
  input  logic [N_THREADS*ADDR_W-1:0] in_addr,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic                        tx_write,
  output logic [ADDR_W-1:0]           tx_line_addr,
  output logic [N_THREADS-1:0]        tx_mask,
  output logic                        busy,
  output logic                        done
);
  localparam int OFFS_W = coal_pkg::offset_bits(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFFS_W;
  localparam int TID_W  = (N_THREADS > 1) ? $clog2(N_THREADS) : 1;

  logic [N_THREADS-1:0]        waiting_q;
  logic                        write_q;
  logic [N_THREADS*ADDR_W-1:0] addr_q;
  logic                        fin_q;
  logic [TID_W-1:0]            lead_idx;
  logic                        any_waiting;
  logic [TAG_W-1:0]            lead_tag;
  logic [N_THREADS-1:0]        hit;
  logic                        load;
  logic                        retire;

  assign load   = in_valid && in_ready;
  assign retire = tx_valid && tx_ready;

  coal_instr_reg #(.N_THREADS(N_THREADS), .ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .load(load), .ld_write(in_write), .ld_active(in_active), .ld_addr(in_addr),
    .retire(retire), .retire_mask(hit),
    .waiting_q(waiting_q), .write_q(write_q), .addr_q(addr_q), .fin_q(fin_q)
  );

  coal_leader_pick #(.N_THREADS(N_THREADS)) u_pick (
    .waiting(waiting_q), .lead_idx(lead_idx), .any_waiting(any_waiting)
  );

  assign lead_tag = addr_q[32'(lead_idx)*ADDR_W+OFFS_W +: TAG_W];

  coal_line_match #(.N_THREADS(N_THREADS), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_match (
    .addrs(addr_q), .waiting(waiting_q), .lead_tag(lead_tag), .hit(hit)
  );

  assign busy         = any_waiting;
  assign in_ready     = !any_waiting;
  assign tx_valid     = any_waiting;
  assign tx_mask      = hit;
  assign tx_write     = write_q;
  assign tx_line_addr = {lead_tag, {OFFS_W{1'b0}}};
  assign done         = fin_q;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int N_THREADS  = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [N_THREADS-1:0]        in_active,
  input logic                        tx_valid,
  input logic                        tx_ready,
  input logic                        tx_write,
  input logic [ADDR_W-1:0]           tx_line_addr,
  input logic [N_THREADS-1:0]        tx_mask,
  input logic                        busy,
  input logic                        done
);
  logic [N_THREADS-1:0] act_q;
  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else if (in_valid && in_ready) act_q <= in_active;
  end

  // R9
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_line_addr) && $stable(tx_mask) && $stable(tx_write));

  // R6
  disjoint_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid || ((tx_mask & $past(tx_mask)) == '0));

  // R7
  only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_mask & ~act_q) == '0) && (tx_mask != '0));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid && !busy);

  // R2
  accept_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !tx_valid);
endmodule

bind simt_coalescer coal_checker #(
  .N_THREADS(N_THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_active(in_active), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_write(tx_write), .tx_line_addr(tx_line_addr), .tx_mask(tx_mask),
  .busy(busy), .done(done)
);

// File: tb/tb_simt_coalescer.sv
`timescale 1ns/1ps
module tb_simt_coalescer;
  localparam int N  = 32;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int OW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_write = 1'b0;
  logic [N-1:0] in_active = '0;
  logic [N*AW-1:0] in_addr = '0;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic tx_write;
  logic [AW-1:0] tx_line_addr;
  logic [N-1:0] tx_mask;
  logic busy, done;

  always #4 clk = ~clk;

  simt_coalescer #(.N_THREADS(N), .ADDR_W(AW), .LINE_BYTES(LB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_active(in_active), .in_addr(in_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_write(tx_write),
    .tx_line_addr(tx_line_addr), .tx_mask(tx_mask), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] addr_arr [N];
  int stall_pct = 50;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [N-1:0] same_line(input logic [N-1:0] p, input int ld);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++)
      if (p[i] && (addr_arr[i][AW-1:OW] == addr_arr[ld][AW-1:OW])) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int line_count(input logic [N-1:0] act);
    logic [N-1:0] p = act;
    int c = 0;
    while (p != '0) begin
      p = p & ~same_line(p, lowest(p));
      c++;
    end
    return c;
  endfunction

  // Called at a negedge; returns at the negedge where done is expected.
  task automatic run_instr(input logic wr, input logic [N-1:0] act, input bit noise);
    logic [N-1:0] pend = act;
    int ntx = 0;
    int exp_tx = line_count(act);
    bit stalled = 1'b0;
    logic [AW-1:0] s_addr;
    logic [N-1:0]  s_mask;
    chk(in_ready === 1'b1, "R10", "in_ready at offer", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b1;
    in_write = wr;
    in_active = act;
    for (int i = 0; i < N; i++) in_addr[i*AW +: AW] = addr_arr[i];
    @(negedge clk);
    in_valid = 1'b0;
    if (act == '0) begin
      chk(done === 1'b1 && tx_valid === 1'b0 && busy === 1'b0, "R8", "empty instr done/tx/busy",
          {61'd0, done, tx_valid, busy}, 64'h4);
      return;
    end
    while (pend != '0) begin
      int ld = lowest(pend);
      logic [N-1:0] em = same_line(pend, ld);
      logic [AW-1:0] ea = {addr_arr[ld][AW-1:OW], {OW{1'b0}}};
      chk(tx_valid === 1'b1 && busy === 1'b1 && in_ready === 1'b0, "R2", "busy while draining",
          {61'd0, tx_valid, busy, in_ready}, 64'h6);
      chk(tx_mask === em, "R4", "merge mask", 64'(tx_mask), 64'(em));
      chk(tx_line_addr === ea, "R5", "line address (leader R3)", 64'(tx_line_addr), 64'(ea));
      chk(tx_write === wr, "R11", "write flag", 64'(tx_write), 64'(wr));
      chk((tx_mask & ~act) == '0, "R7", "inactive thread in mask", 64'(tx_mask & ~act), 64'd0);
      if (stalled)
        chk(tx_mask === s_mask && tx_line_addr === s_addr, "R9", "held under stall",
            64'(tx_line_addr), 64'(s_addr));
      if (noise) begin
        in_valid = 1'b1;
        in_active = ~act;
        in_write = ~wr;
        in_addr = '1;
      end
      tx_ready = ($urandom_range(99) >= stall_pct);
      s_addr = tx_line_addr;
      s_mask = tx_mask;
      stalled = !tx_ready;
      if (tx_ready) begin
        pend = pend & ~em;
        ntx++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      tx_ready = 1'b0;
    end
    chk(done === 1'b1 && busy === 1'b0 && tx_valid === 1'b0, "R10", "done pulse after last tx",
        {61'd0, done, busy, tx_valid}, 64'h4);
    chk(ntx == exp_tx, "R12", "transaction count", 64'(ntx), 64'(exp_tx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && in_ready === 1'b1, "R1",
        "state in reset", {60'd0, tx_valid, busy, done, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && in_ready === 1'b1, "R1",
        "state after reset", {60'd0, tx_valid, busy, done, in_ready}, 64'h1);

    // R4: all threads in one line -> one transaction
    for (int i = 0; i < N; i++) addr_arr[i] = 32'h1000_0040 + 32'(i);
    run_instr(1'b0, '1, 1'b0);
    // R12: stride of two lines -> one transaction per thread
    for (int i = 0; i < N; i++) addr_arr[i] = 32'h2000_0000 + 32'(i * 128);
    run_instr(1'b1, '1, 1'b0);
    // R8: nothing active, offered in the done cycle
    run_instr(1'b0, '0, 1'b0);
    // R3: only the highest thread active
    run_instr(1'b1, 32'h8000_0000, 1'b0);
    // R4 boundary: bytes 63 and 64 are in different lines; 0 and 63 share one
    for (int i = 0; i < N; i++) addr_arr[i] = 32'h0000_0000 + ((i % 2 == 0) ? 32'd63 : 32'd64);
    addr_arr[5] = 32'd0;
    run_instr(1'b0, 32'h0000_00ff, 1'b0);
    // R2: offers while busy are ignored
    for (int i = 0; i < N; i++) addr_arr[i] = 32'h3000_0000 + 32'((N - 1 - i) % 4) * 64 + 32'(i);
    run_instr(1'b1, 32'h5a5a_f00f, 1'b1);
    // random mixes, back to back so done meets the next acceptance (R10)
    for (int t = 0; t < 300; t++) begin
      logic [AW-1:0] base = $urandom() & 32'hffff_f000;
      int spread = $urandom_range(1, 8);
      stall_pct = $urandom_range(0, 80);
      for (int i = 0; i < N; i++)
        addr_arr[i] = ($urandom_range(9) == 0) ? $urandom()
                    : base + 32'($urandom_range(spread - 1)) * 64 + 32'($urandom_range(63));
      run_instr(1'($urandom_range(1)), (t % 17 == 0) ? '0 : $urandom(), (t % 5 == 0));
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10", "done lasts one cycle",
        {62'd0, done, busy}, 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule